// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

This block raises a one-cycle reset request when firmware stops servicing it in time. Which of three behaviours it has is fixed at reset by a 16-bit selection word from non-volatile storage. In software mode the timer sits idle until firmware arms it. The arming write also picks the count source and interval. After that the timer cannot be stopped. In either hardware mode the timer runs from reset on a fixed source. The two hardware modes differ only in how they react to standby.

Counting is done in two stages driven by tick strobes from three external prescalers: a timebase, a watch prescaler and a sub-oscillator timer. The first stage counts ticks of the selected source. The second stage is a single flag that is set on the first interval boundary and fires the request on the second. Servicing, standby entry and a clear of the selected prescaler all reset the count, so the real timeout lies between one and two nominal intervals.

Top module: `dual_mode_wdt`

## Requirements
- R1: The selection word is captured on the first clock edge after reset and held until the next reset. A596h selects software mode. A597h selects hardware mode that freezes in standby. Every other value selects hardware mode that ignores standby.
- R2: In software mode the timer stays stopped and never requests reset until a control write carries key 0101b. Writes with any other key leave it stopped.
- R3: The arming write captures the 3-bit clock select. After arming, later clock-select values and writes with keys other than 0101b change neither the interval nor the running state.
- R4: Clock select decode is as follows. With bit0 = 1 the source is the sub-oscillator, interval 2^SC_W ticks. Code 100b is the watch prescaler, 2^WP_LONG_W. Code 110b is the watch prescaler, 2^WP_SHORT_W. Code 000b is the timebase, 2^TB_LONG_W. Code 010b is the timebase, 2^TB_SHORT_W.
- R5: In both hardware modes the timer runs from reset with the select fixed at 001b. Written clock-select values have no effect.
- R6: The request output is low in and after reset. With ticks on every cycle, it rises directly after the 2*2^W-th counted tick edge following a clear of the selected source.
- R7: While running, a write with key 0101b clears only the second stage. If it lands just after the first boundary, the request comes at 3*2^W ticks instead of 2*2^W.
- R8: A clear strobe from the selected prescaler resets both stages. Clear strobes from unselected prescalers have no effect.
- R9: A rising edge on the standby input clears the second stage in software mode and in A597h mode. In the other hardware mode it has no effect.
- R10: In A597h mode, ticks are not counted while standby is high. Counting resumes from the held value when standby falls.
- R11: Each request is exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_id_i | input | 16 | Mode selection word from non-volatile storage |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_key_i | input | 4 | Control key field of the write |
| ctl_sel_i | input | 3 | Clock-select field of the write |
| tb_tick_i | input | 1 | Timebase tick strobe |
| wp_tick_i | input | 1 | Watch prescaler tick strobe |
| sc_tick_i | input | 1 | Sub-oscillator timer tick strobe |
| tb_clr_i | input | 1 | Timebase clear strobe |
| wp_clr_i | input | 1 | Watch prescaler clear strobe |
| sc_clr_i | input | 1 | Sub-oscillator timer clear strobe |
| standby_i | input | 1 | High while the chip is in a standby mode |
| wdt_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
The hardest case to reach is the hidden second-stage flag. A timeout of one to two intervals alone cannot tell whether a service or a standby entry cleared it. The bench first clears the selected prescaler to pin the phase of the first stage. It then places the service write, the standby pulse or the foreign clear exactly one or two ticks after the first boundary. The request then moves by a full interval when the flag was cleared and stays put when it was not. Freezing in A597h mode is told apart from clearing by holding standby before the first boundary, where only the added frozen cycles shift the timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    MODE_SW        = 2'd0,
    MODE_HW_HALT   = 2'd1,
    MODE_HW_ALWAYS = 2'd2
  } wdt_mode_e;

  typedef enum logic [1:0] {
    SRC_TB = 2'd0,
    SRC_WP = 2'd1,
    SRC_SC = 2'd2
  } wdt_src_e;

  localparam logic [15:0] ID_SOFT      = 16'hA596;
  localparam logic [15:0] ID_HW_HALT   = 16'hA597;
  localparam logic [3:0]  KEY_ARM      = 4'b0101;
  localparam logic [2:0]  SEL_HW_FIXED = 3'b001;

  function automatic wdt_mode_e decode_id(input logic [15:0] id);
    if (id == ID_SOFT)         return MODE_SW;
    else if (id == ID_HW_HALT) return MODE_HW_HALT;
    else                       return MODE_HW_ALWAYS;
  endfunction

  function automatic wdt_src_e decode_src(input logic [2:0] sel);
    if (sel[0])      return SRC_SC;
    else if (sel[2]) return SRC_WP;
    else             return SRC_TB;
  endfunction

endpackage

// File: rtl/wdt_mode_ctrl.sv
module wdt_mode_ctrl
  import wdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] sel_id_i,
  input  logic        ctl_we_i,
  input  logic [3:0]  ctl_key_i,
  input  logic [2:0]  ctl_sel_i,
  output wdt_mode_e   mode_o,
  output logic        run_o,
  output logic [2:0]  sel_o,
  output logic        service_o
);

  logic      id_valid_q;
  wdt_mode_e mode_q, mode_n;
  logic      run_q, run_n;
  logic [2:0] sel_q, sel_n;
  logic      key_ok, arm;

  always_comb begin
    key_ok    = ctl_we_i && (ctl_key_i == KEY_ARM);
    arm       = id_valid_q && (mode_q == MODE_SW) && !run_q && key_ok;
    service_o = run_q && key_ok;
    mode_n    = decode_id(sel_id_i);
    run_n     = run_q;
    if (!id_valid_q) run_n = (mode_n != MODE_SW);
    else if (arm)    run_n = 1'b1;
    sel_n     = ctl_sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_valid_q <= 1'b0;
      mode_q     <= MODE_SW;
      run_q      <= 1'b0;
      sel_q      <= 3'b000;
    end else begin
      id_valid_q <= 1'b1;
      if (!id_valid_q) mode_q <= mode_n;
      run_q <= run_n;
      if (arm) sel_q <= sel_n;
    end
  end

  assign mode_o = mode_q;
  assign run_o  = run_q;
  assign sel_o  = (mode_q == MODE_SW) ? sel_q : SEL_HW_FIXED;

  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_q |=> $stable(mode_q)); // R1
  AST_RUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q); // R3
  AST_SEL_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && id_valid_q) |=> $stable(sel_o)); // R3
  AST_HW_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_q && mode_q != MODE_SW) |=> run_q); // R5

endmodule

// File: rtl/wdt_src_sel.sv
module wdt_src_sel
  import wdt_pkg::*;
#(
  parameter int unsigned DIV_W      = 16,
  parameter int unsigned TB_LONG_W  = 14,
  parameter int unsigned TB_SHORT_W = 13,
  parameter int unsigned WP_LONG_W  = 14,
  parameter int unsigned WP_SHORT_W = 13,
  parameter int unsigned SC_W       = 16
) (
  input  logic [2:0]       sel_i,
  input  logic [2:0]       tick_i,
  input  logic [2:0]       clr_i,
  output logic             tick_o,
  output logic             clr_o,
  output logic [DIV_W-1:0] mask_o
);

  wdt_src_e    src;
  int unsigned width;

  always_comb begin
    src = decode_src(sel_i);
    case (src)
      SRC_SC: begin
        tick_o = tick_i[2];
        clr_o  = clr_i[2];
        width  = SC_W;
      end
      SRC_WP: begin
        tick_o = tick_i[1];
        clr_o  = clr_i[1];
        width  = sel_i[1] ? WP_SHORT_W : WP_LONG_W;
      end
      default: begin
        tick_o = tick_i[0];
        clr_o  = clr_i[0];
        width  = sel_i[1] ? TB_SHORT_W : TB_LONG_W;
      end
    endcase
  end

  for (genvar g = 0; g < DIV_W; g++) begin : g_mask
    assign mask_o[g] = (32'(g) < width);
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic             src_clr_i,
  input  logic             stage_clr_i,
  input  logic [DIV_W-1:0] mask_i,
  output logic             req_o
);

  logic [DIV_W-1:0] div_q, div_n;
  logic             half_q, half_n;
  logic             req_q, req_n;
  logic             boundary;

  always_comb begin
    boundary = tick_en_i && ((div_q & mask_i) == mask_i);
    div_n    = tick_en_i ? div_q + DIV_W'(1) : div_q;
    half_n   = half_q;
    req_n    = 1'b0;
    if (src_clr_i) begin
      div_n  = '0;
      half_n = 1'b0;
    end else if (stage_clr_i) begin
      half_n = 1'b0;
    end else if (boundary) begin
      req_n  = half_q;
      half_n = !half_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      half_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      div_q  <= div_n;
      half_q <= half_n;
      req_q  <= req_n;
    end
  end

  assign req_o = req_q;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q); // R11
  AST_REQ_AFTER_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(half_q)); // R6
  AST_SRC_CLR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_clr_i |=> (div_q == '0 && !half_q && !req_q)); // R8
  AST_FROZEN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_en_i && !src_clr_i) |=> $stable(div_q)); // R10

endmodule

// File: rtl/dual_mode_wdt.sv
module dual_mode_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned TB_LONG_W  = 14,
  parameter int unsigned TB_SHORT_W = 13,
  parameter int unsigned WP_LONG_W  = 14,
  parameter int unsigned WP_SHORT_W = 13,
  parameter int unsigned SC_W       = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] sel_id_i,
  input  logic        ctl_we_i,
  input  logic [3:0]  ctl_key_i,
  input  logic [2:0]  ctl_sel_i,
  input  logic        tb_tick_i,
  input  logic        wp_tick_i,
  input  logic        sc_tick_i,
  input  logic        tb_clr_i,
  input  logic        wp_clr_i,
  input  logic        sc_clr_i,
  input  logic        standby_i,
  output logic        wdt_rst_o
);

  localparam int unsigned MAX_TB = (TB_LONG_W > TB_SHORT_W) ? TB_LONG_W : TB_SHORT_W;
  localparam int unsigned MAX_WP = (WP_LONG_W > WP_SHORT_W) ? WP_LONG_W : WP_SHORT_W;
  localparam int unsigned MAX_PS = (MAX_TB > MAX_WP) ? MAX_TB : MAX_WP;
  localparam int unsigned DIV_W  = (MAX_PS > SC_W) ? MAX_PS : SC_W;

  wdt_mode_e        mode;
  logic             run, service;
  logic [2:0]       sel;
  logic             src_tick, src_clr;
  logic [DIV_W-1:0] mask;
  logic             stby_q;
  logic             stby_entry, freeze, tick_en, stage_clr, clr_en;

  wdt_mode_ctrl u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_id_i  (sel_id_i),
    .ctl_we_i  (ctl_we_i),
    .ctl_key_i (ctl_key_i),
    .ctl_sel_i (ctl_sel_i),
    .mode_o    (mode),
    .run_o     (run),
    .sel_o     (sel),
    .service_o (service)
  );

  wdt_src_sel #(
    .DIV_W      (DIV_W),
    .TB_LONG_W  (TB_LONG_W),
    .TB_SHORT_W (TB_SHORT_W),
    .WP_LONG_W  (WP_LONG_W),
    .WP_SHORT_W (WP_SHORT_W),
    .SC_W       (SC_W)
  ) u_src (
    .sel_i  (sel),
    .tick_i ({sc_tick_i, wp_tick_i, tb_tick_i}),
    .clr_i  ({sc_clr_i, wp_clr_i, tb_clr_i}),
    .tick_o (src_tick),
    .clr_o  (src_clr),
    .mask_o (mask)
  );

  always_comb begin
    stby_entry = standby_i && !stby_q;
    freeze     = (mode == MODE_HW_HALT) && standby_i;
    tick_en    = run && src_tick && !freeze;
    clr_en     = run && src_clr;
    stage_clr  = service || (run && stby_entry && (mode != MODE_HW_ALWAYS));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stby_q <= 1'b0;
    else         stby_q <= standby_i;
  end

  wdt_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_en_i   (tick_en),
    .src_clr_i   (clr_en),
    .stage_clr_i (stage_clr),
    .mask_i      (mask),
    .req_o       (wdt_rst_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_SW && !run) |-> !wdt_rst_o); // R2
  AST_HALT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_HW_HALT && standby_i && !clr_en) |=> !wdt_rst_o); // R10

endmodule

// File: tb/tb_dual_mode_wdt.sv
module tb_dual_mode_wdt;
  localparam int CLK_P = 10;
  localparam int TBL = 5, TBS = 3, WPL = 6, WPS = 4, SCW = 7;

  logic clk = 1'b0;
  logic rst_ni;
  logic [15:0] sel_id;
  logic we;
  logic [3:0] key;
  logic [2:0] csel;
  logic tb_clr, wp_clr, sc_clr, stby;
  logic wdt_rst;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_mode_wdt #(.TB_LONG_W(TBL), .TB_SHORT_W(TBS), .WP_LONG_W(WPL),
                  .WP_SHORT_W(WPS), .SC_W(SCW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_id_i(sel_id), .ctl_we_i(we),
    .ctl_key_i(key), .ctl_sel_i(csel), .tb_tick_i(1'b1), .wp_tick_i(1'b1),
    .sc_tick_i(1'b1), .tb_clr_i(tb_clr), .wp_clr_i(wp_clr), .sc_clr_i(sc_clr),
    .standby_i(stby), .wdt_rst_o(wdt_rst));

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // kinds: 1 key 0101 write, 2 key 1010 write, 3 standby, 4 wp clear, 5 sc clear
  task automatic apply(input int kind, input bit on, input logic [2:0] s);
    we = on && (kind == 1 || kind == 2);
    key = (kind == 1) ? 4'b0101 : 4'b1010;
    csel = s;
    stby = on && kind == 3;
    wp_clr = on && kind == 4;
    sc_clr = on && kind == 5;
  endtask

  task automatic do_reset(input logic [15:0] id);
    @(negedge clk);
    rst_ni = 1'b0;
    apply(0, 0, 3'b000);
    tb_clr = 1'b0;
    sel_id = id;
    repeat (3) @(negedge clk);
    chk("R6 reset low", int'(wdt_rst), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // reference edge E0: kind 5 = sc clear (hardware), kind 1 = arm write
  task automatic start_ref(input int kind, input logic [2:0] s);
    apply(kind, 1, s);
    @(negedge clk);
    apply(0, 0, 3'b000);
  endtask

  task automatic measure(input string rq, input int exp_c, input int lim,
                         input int ev_c, input int ev_kind, input int ev_len,
                         input logic [2:0] ev_sel);
    int first = -1;
    int highs = 0;
    for (int c = 1; c <= lim; c++) begin
      apply(ev_kind, (c >= ev_c) && (c < ev_c + ev_len), ev_sel);
      @(negedge clk);
      if (wdt_rst) begin
        highs++;
        if (first < 0) first = c;
      end
    end
    apply(0, 0, 3'b000);
    chk(rq, first, exp_c);
    if (exp_c > 0) chk("R11 pulse width", highs, 1);
  endtask

  function automatic int sel_w(input logic [2:0] s);
    if (s[0]) return SCW;
    if (s[2]) return s[1] ? WPS : WPL;
    return s[1] ? TBS : TBL;
  endfunction

  localparam int SI = 1 << SCW;
  localparam int QI = 1 << WPS;

  initial begin
    rst_ni = 1'b0; sel_id = 16'h0; tb_clr = 1'b0;
    apply(0, 0, 3'b000);

    // hardware, runs in all modes
    do_reset(16'h0000); start_ref(5, 0);
    measure("R1 R5 R6 hw basic timeout", 2*SI, 2*SI+3, 0, 0, 0, 0);
    do_reset(16'h1234); start_ref(5, 0);
    measure("R5 hw sel write ignored", 2*SI, 2*SI+3, 3, 1, 1, 3'b100);
    do_reset(16'h0000); start_ref(5, 0);
    measure("R7 hw service after boundary", 3*SI, 3*SI+3, SI+1, 1, 1, 0);
    do_reset(16'h0000); start_ref(5, 0);
    measure("R8 unselected clear ignored", 2*SI, 2*SI+3, SI+1, 4, 1, 0);
    do_reset(16'h0000); start_ref(5, 0);
    measure("R8 selected clear restarts", SI+1+2*SI, 3*SI+4, SI+1, 5, 1, 0);
    do_reset(16'hFFFF); start_ref(5, 0);
    measure("R9 run-all ignores standby", 2*SI, 2*SI+3, SI+2, 3, 3, 0);

    // hardware, halts in standby
    do_reset(16'hA597); start_ref(5, 0);
    measure("R9 R10 halt mode standby clears and freezes", 3*SI+3, 3*SI+6, SI+2, 3, 3, 0);
    do_reset(16'hA597); start_ref(5, 0);
    measure("R10 frozen count preserved", 2*SI+5, 2*SI+8, 2, 3, 5, 0);

    // software mode idle
    do_reset(16'hA596);
    measure("R2 idle and bad key ignored", -1, 4*SI+40, 5, 2, 1, 3'b001);

    // software mode select sweep
    for (int s = 0; s < 8; s++) begin
      do_reset(16'hA596); start_ref(1, 3'(s));
      measure($sformatf("R4 R3 sel=%0d interval", s), 2*(1 << sel_w(3'(s))),
              2*(1 << sel_w(3'(s)))+3, 0, 0, 0, 0);
    end

    do_reset(16'hA596); start_ref(1, 3'b110);
    measure("R3 sel locked after arm", 2*QI, 2*QI+3, 3, 1, 1, 3'b001);
    do_reset(16'hA596); start_ref(1, 3'b110);
    measure("R3 bad key cannot stop", 2*QI, 2*QI+3, QI+4, 2, 1, 3'b000);
    do_reset(16'hA596); start_ref(1, 3'b110);
    measure("R7 sw service after boundary", 3*QI, 3*QI+3, QI+1, 1, 1, 3'b110);
    do_reset(16'hA596); start_ref(1, 3'b110);
    measure("R8 sw selected clear", QI+1+2*QI, 3*QI+4, QI+1, 4, 1, 0);
    do_reset(16'hA596); start_ref(1, 3'b110);
    measure("R8 sw unselected clear", 2*QI, 2*QI+3, QI+1, 5, 1, 0);
    do_reset(16'hA596); start_ref(1, 3'b110);
    measure("R9 sw standby entry clears", 3*QI, 3*QI+3, QI+2, 3, 2, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P*150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule